// File: doc/BRIEF.md
# Next-PC Unit with Delay Slot

This block owns the fetch program counter of a 32-bit load/store processor whose control transfers have one delay slot. Each cycle it is handed the decoded fields of the instruction held at the current PC (major opcode, function code, the rt and rd selectors, the 16-bit displacement and the 26-bit jump index) together with the two register operands. It decides whether that instruction moves control, works out where to, and holds that destination in a pending-target register. The instruction that follows a taken transfer still executes. Only after it retires does the PC load the held destination.

Linking forms produce a register write request in the same cycle. The write goes to register 31, or to the rd selector for the register-indirect linking form, and its value is the transfer's own address plus eight. Fetch, the register file and the ALU stay outside. The decoder feeds the fields in, and the register file takes the link write out.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` loads the `RESET_VEC` parameter and `pendValid` clears. This also holds when a pending target was outstanding.
- R2: With no pending target, an instruction that does not move control advances `pc` by 4 and leaves `pendValid` low. This includes opcode 0x00 with any function code other than 0x08 or 0x09.
- R3: A taken transfer at address P sets `pc` to P+4 and raises `pendValid` with the destination in `pendTarget`. In the next cycle (the delay slot), `pc` loads `pendTarget` and `pendValid` drops.
- R4: Relative destination = P + 4 + (displacement sign-extended, shifted left 2). Opcode 0x04 is taken when the operands are equal. Opcode 0x05 is taken when they differ. Opcode 0x06 is taken when rs ≤ 0 as a signed value. Opcode 0x07 is taken when rs > 0 as a signed value, and the rt operand is ignored.
- R5: Opcode 0x01 selects its form from the rt field. 0x00 is taken when rs < 0. 0x01 is taken when rs ≥ 0. 0x10 and 0x11 are the same two tests with linking. Any other rt value does not move control.
- R6: Opcodes 0x02 (jump) and 0x03 (jump and link) go to {bits 31:28 of P+4, index, 2'b00}. The region therefore comes from the delay-slot address.
- R7: Opcode 0x00 with function 0x08 (register jump) and function 0x09 (register jump and link) go to the full 32-bit rs value.
- R8: Opcode 0x03, rt forms 0x10 and 0x11 of opcode 0x01 (taken or not), and function 0x09 raise `linkWe` in the same cycle with `linkData` = P+8. `linkReg` is 31, except for function 0x09, where it is the rd field.
- R9: An instruction presented while `pendValid` is high is treated as plain. It raises no link write and sets no new pending target, and `pc` still goes to the held destination.
- R10: `pendValid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Major opcode of the instruction at `pc` |
| funct | input | 6 | Function code (opcode 0x00) |
| rtField | input | 5 | rt selector; picks the form under opcode 0x01 |
| rdField | input | 5 | rd selector; link register for function 0x09 |
| offset | input | 16 | Branch displacement in words |
| jumpIndex | input | 26 | Absolute jump word index |
| rsVal | input | 32 | First register operand |
| rtVal | input | 32 | Second register operand |
| pc | output | 32 | Address of the instruction to fetch and execute |
| pendValid | output | 1 | Current instruction is a delay slot with a held destination |
| pendTarget | output | 32 | Held destination |
| linkWe | output | 1 | Link write request |
| linkReg | output | 5 | Link write register number |
| linkData | output | 32 | Link write value |

## Verification
A new transfer can arrive in the same cycle that a held destination retires. That is the case where a branch or jump sits in the delay slot. The bench provokes it by presenting a taken equality branch and then, in its slot, a jump-and-link to a different place. It judges the result by `linkWe` staying low during the slot, `pc` landing on the branch destination rather than the jump's, and `pendValid` falling. A second collision puts reset on top of an outstanding destination, and reset must win.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_REGIMM  = 6'h01;
  localparam logic [5:0] OP_J       = 6'h02;
  localparam logic [5:0] OP_JAL     = 6'h03;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_BNE     = 6'h05;
  localparam logic [5:0] OP_BLEZ    = 6'h06;
  localparam logic [5:0] OP_BGTZ    = 6'h07;
  localparam logic [5:0] FN_JR      = 6'h08;
  localparam logic [5:0] FN_JALR    = 6'h09;
  localparam logic [4:0] RI_LT      = 5'h00;
  localparam logic [4:0] RI_GE      = 5'h01;
  localparam logic [4:0] RI_LTL     = 5'h10;
  localparam logic [4:0] RI_GEL     = 5'h11;

  typedef enum logic [1:0] {TGT_REL, TGT_ABS, TGT_REG} tgtSel_e;

  typedef struct packed {
    logic    xfer;    // control moves after the slot
    tgtSel_e tgtSel;  // where the destination comes from
    logic    linkEn;  // request a link write
    logic    linkRd;  // link goes to rd instead of the fixed register
  } npcStrobe_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int REG_W = 5
) (
  input  logic [5:0]       opcode,
  input  logic [5:0]       funct,
  input  logic [REG_W-1:0] rtField,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  input  logic             pendValid,
  output npcStrobe_t       strobe
);
  logic rsNeg, rsZero, opsEqual, riKnown, riCond;

  assign rsNeg    = rsVal[XLEN-1];
  assign rsZero   = (rsVal == '0);
  assign opsEqual = (rsVal == rtVal);
  assign riKnown  = (rtField == REG_W'(RI_LT))  || (rtField == REG_W'(RI_GE)) ||
                    (rtField == REG_W'(RI_LTL)) || (rtField == REG_W'(RI_GEL));
  assign riCond   = rtField[0] ? !rsNeg : rsNeg;

  always_comb begin
    strobe = '{xfer: 1'b0, tgtSel: TGT_REL, linkEn: 1'b0, linkRd: 1'b0};
    if (!pendValid) begin
      unique case (opcode)
        OP_BEQ:  strobe.xfer = opsEqual;
        OP_BNE:  strobe.xfer = !opsEqual;
        OP_BLEZ: strobe.xfer = rsNeg || rsZero;
        OP_BGTZ: strobe.xfer = !rsNeg && !rsZero;
        OP_REGIMM: begin
          strobe.xfer   = riKnown && riCond;
          strobe.linkEn = riKnown && rtField[REG_W-1];
        end
        OP_J: begin
          strobe.xfer   = 1'b1;
          strobe.tgtSel = TGT_ABS;
        end
        OP_JAL: begin
          strobe.xfer   = 1'b1;
          strobe.tgtSel = TGT_ABS;
          strobe.linkEn = 1'b1;
        end
        OP_SPECIAL: begin
          if (funct == FN_JR || funct == FN_JALR) begin
            strobe.xfer   = 1'b1;
            strobe.tgtSel = TGT_REG;
            strobe.linkEn = (funct == FN_JALR);
            strobe.linkRd = (funct == FN_JALR);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000,
  parameter int              OFF_W     = 16,
  parameter int              IDX_W     = 26,
  parameter int              REG_W     = 5,
  parameter int              LINK_REG  = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  npcStrobe_t       strobe,
  input  logic [OFF_W-1:0] offset,
  input  logic [IDX_W-1:0] jumpIndex,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [REG_W-1:0] rdField,
  output logic [XLEN-1:0]  pc,
  output logic             pendValid,
  output logic [XLEN-1:0]  pendTarget,
  output logic             linkWe,
  output logic [REG_W-1:0] linkReg,
  output logic [XLEN-1:0]  linkData
);
  localparam int REGION_W = XLEN - IDX_W - 2;
  localparam int SEXT_W   = XLEN - OFF_W - 2;

  logic [XLEN-1:0] seqPc, relTgt, absTgt, newTgt;

  assign seqPc  = pc + XLEN'(4);
  assign relTgt = seqPc + {{SEXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign absTgt = {seqPc[XLEN-1 -: REGION_W], jumpIndex, 2'b00};

  always_comb begin
    unique case (strobe.tgtSel)
      TGT_ABS: newTgt = absTgt;
      TGT_REG: newTgt = rsVal;
      default: newTgt = relTgt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= RESET_VEC;
      pendValid  <= 1'b0;
      pendTarget <= '0;
    end else if (pendValid) begin
      pc        <= pendTarget;
      pendValid <= 1'b0;
    end else begin
      pc <= seqPc;
      if (strobe.xfer) begin
        pendValid  <= 1'b1;
        pendTarget <= newTgt;
      end
    end
  end

  assign linkWe   = strobe.linkEn;
  assign linkReg  = strobe.linkRd ? rdField : REG_W'(LINK_REG);
  assign linkData = pc + XLEN'(8);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000,
  parameter int              OFF_W     = 16,
  parameter int              IDX_W     = 26,
  parameter int              REG_W     = 5,
  parameter int              LINK_REG  = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       opcode,
  input  logic [5:0]       funct,
  input  logic [REG_W-1:0] rtField,
  input  logic [REG_W-1:0] rdField,
  input  logic [OFF_W-1:0] offset,
  input  logic [IDX_W-1:0] jumpIndex,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  output logic [XLEN-1:0]  pc,
  output logic             pendValid,
  output logic [XLEN-1:0]  pendTarget,
  output logic             linkWe,
  output logic [REG_W-1:0] linkReg,
  output logic [XLEN-1:0]  linkData
);
  npcStrobe_t strobe;

  npc_ctrl #(.XLEN(XLEN), .REG_W(REG_W)) u_ctrl (
    .opcode(opcode), .funct(funct), .rtField(rtField),
    .rsVal(rsVal), .rtVal(rtVal), .pendValid(pendValid), .strobe(strobe)
  );

  npc_datapath #(
    .XLEN(XLEN), .RESET_VEC(RESET_VEC), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .REG_W(REG_W), .LINK_REG(LINK_REG)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .offset(offset),
    .jumpIndex(jumpIndex), .rsVal(rsVal), .rdField(rdField),
    .pc(pc), .pendValid(pendValid), .pendTarget(pendTarget),
    .linkWe(linkWe), .linkReg(linkReg), .linkData(linkData)
  );
endmodule

// File: rtl/npc_unit_checker.sv
module npc_unit_checker
  import npc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000,
  parameter int              REG_W     = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [5:0]       opcode,
  input logic [XLEN-1:0]  pc,
  input logic             pendValid,
  input logic [XLEN-1:0]  pendTarget,
  input logic             linkWe,
  input logic [REG_W-1:0] linkReg,
  input npcStrobe_t       strobe
);
  logic rstQ = 1'b0;
  always_ff @(posedge clk) rstQ <= rst;

  p_reset_vec_r1: assert property (@(posedge clk) disable iff (rst)
    rstQ |-> (pc == RESET_VEC && !pendValid));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!pendValid && !strobe.xfer) |=> (pc == $past(pc) + XLEN'(4) && !pendValid));

  p_taken_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (!pendValid && strobe.xfer) |=> (pendValid && pc == $past(pc) + XLEN'(4)));

  p_slot_retire_r3: assert property (@(posedge clk) disable iff (rst)
    pendValid |=> (pc == $past(pendTarget)));

  p_jal_link_r8: assert property (@(posedge clk) disable iff (rst)
    (linkWe && opcode == OP_JAL) |-> (linkReg == REG_W'(31)));

  p_slot_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    pendValid |-> (!linkWe && !strobe.xfer));

  p_single_pend_r10: assert property (@(posedge clk) disable iff (rst)
    pendValid |=> !pendValid);
endmodule

bind npc_unit npc_unit_checker #(.XLEN(XLEN), .RESET_VEC(RESET_VEC), .REG_W(REG_W)) u_npcChk (
  .clk(clk), .rst(rst), .opcode(opcode), .pc(pc), .pendValid(pendValid),
  .pendTarget(pendTarget), .linkWe(linkWe), .linkReg(linkReg), .strobe(strobe)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  localparam logic [31:0] RV = 32'hBFC0_0000;

  typedef struct packed {
    logic [31:0] startPc;
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [4:0]  rtF;
    logic [4:0]  rdF;
    logic [15:0] off;
    logic [25:0] idx;
    logic [31:0] rsV;
    logic [31:0] rtV;
    logic        taken;
    logic [31:0] target;
    logic        lw;
    logic [4:0]  lr;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{32'h0,        6'h04, 6'h00, 5'h00, 5'h0, 16'h1f94, 26'h0,     32'h2,        32'h2,        1'b1, 32'h7e54,     1'b0, 5'd0},
    '{32'h200,      6'h04, 6'h00, 5'h00, 5'h0, 16'hff94, 26'h0,     32'h2,        32'h2,        1'b1, 32'h54,       1'b0, 5'd0},
    '{32'h0,        6'h04, 6'h00, 5'h00, 5'h0, 16'h1f94, 26'h0,     32'h2,        32'h3,        1'b0, 32'h0,        1'b0, 5'd0},
    '{32'h0,        6'h05, 6'h00, 5'h00, 5'h0, 16'h1f94, 26'h0,     32'h2,        32'h3,        1'b1, 32'h7e54,     1'b0, 5'd0},
    '{32'h0,        6'h05, 6'h00, 5'h00, 5'h0, 16'h1f94, 26'h0,     32'h2,        32'h2,        1'b0, 32'h0,        1'b0, 5'd0},
    '{32'h0,        6'h06, 6'h00, 5'h00, 5'h0, 16'h1f94, 26'h0,     32'h0,        32'h9,        1'b1, 32'h7e54,     1'b0, 5'd0},
    '{32'h0,        6'h06, 6'h00, 5'h00, 5'h0, 16'h1f94, 26'h0,     32'h1,        32'h0,        1'b0, 32'h0,        1'b0, 5'd0},
    '{32'h0,        6'h07, 6'h00, 5'h00, 5'h0, 16'h1f94, 26'h0,     32'h2,        32'h80000000, 1'b1, 32'h7e54,     1'b0, 5'd0},
    '{32'h0,        6'h07, 6'h00, 5'h00, 5'h0, 16'h1f94, 26'h0,     32'h80000000, 32'h5,        1'b0, 32'h0,        1'b0, 5'd0},
    '{32'h0,        6'h01, 6'h00, 5'h00, 5'h0, 16'h1f94, 26'h0,     32'hffffffff, 32'h0,        1'b1, 32'h7e54,     1'b0, 5'd0},
    '{32'h0,        6'h01, 6'h00, 5'h01, 5'h0, 16'h1f94, 26'h0,     32'h2,        32'h0,        1'b1, 32'h7e54,     1'b0, 5'd0},
    '{32'h0,        6'h01, 6'h00, 5'h11, 5'h5, 16'h1f94, 26'h0,     32'h2,        32'h0,        1'b1, 32'h7e54,     1'b1, 5'd31},
    '{32'h0,        6'h01, 6'h00, 5'h10, 5'h0, 16'h1f94, 26'h0,     32'h2,        32'h0,        1'b0, 32'h0,        1'b1, 5'd31},
    '{32'h0,        6'h01, 6'h00, 5'h05, 5'h0, 16'h1f94, 26'h0,     32'hffffffff, 32'h0,        1'b0, 32'h0,        1'b0, 5'd0},
    '{32'h0,        6'h02, 6'h00, 5'h00, 5'h0, 16'h0,    26'h298c2, 32'h0,        32'h0,        1'b1, 32'ha6308,    1'b0, 5'd0},
    '{32'h10000000, 6'h02, 6'h00, 5'h00, 5'h0, 16'h0,    26'h24,    32'h0,        32'h0,        1'b1, 32'h10000090, 1'b0, 5'd0},
    '{32'h1ffffffc, 6'h02, 6'h00, 5'h00, 5'h0, 16'h0,    26'h0,     32'h0,        32'h0,        1'b1, 32'h20000000, 1'b0, 5'd0},
    '{32'h4,        6'h03, 6'h00, 5'h00, 5'h0, 16'h0,    26'h298c2, 32'h0,        32'h0,        1'b1, 32'ha6308,    1'b1, 5'd31},
    '{32'h4,        6'h00, 6'h08, 5'h00, 5'h0, 16'h0,    26'h0,     32'ha6308,    32'h0,        1'b1, 32'ha6308,    1'b0, 5'd0},
    '{32'h4,        6'h00, 6'h09, 5'h00, 5'h7, 16'h0,    26'h0,     32'ha6308,    32'h0,        1'b1, 32'ha6308,    1'b1, 5'd7},
    '{32'h0,        6'h00, 6'h21, 5'h00, 5'h8, 16'h0,    26'h0,     32'h7fffffff, 32'h1,        1'b0, 32'h0,        1'b0, 5'd0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  opcode, funct;
  logic [4:0]  rtField, rdField, linkReg;
  logic [15:0] offset;
  logic [25:0] jumpIndex;
  logic [31:0] rsVal, rtVal, pc, pendTarget, linkData;
  logic        pendValid, linkWe;
  int nChecks = 0;
  int nErrors = 0;

  always #4 clk = ~clk;

  npc_unit #(.RESET_VEC(RV)) dut (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .rtField(rtField),
    .rdField(rdField), .offset(offset), .jumpIndex(jumpIndex), .rsVal(rsVal),
    .rtVal(rtVal), .pc(pc), .pendValid(pendValid), .pendTarget(pendTarget),
    .linkWe(linkWe), .linkReg(linkReg), .linkData(linkData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] rt,
                       input logic [4:0] rd, input logic [15:0] off, input logic [25:0] idx,
                       input logic [31:0] rs, input logic [31:0] rtv);
    opcode = op; funct = fn; rtField = rt; rdField = rd;
    offset = off; jumpIndex = idx; rsVal = rs; rtVal = rtv;
  endtask

  task automatic driveNop();
    drive(6'h00, 6'h21, 5'h0, 5'h0, 16'h0, 26'h0, 32'h0, 32'h0);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic jumpTo(input logic [31:0] addr);
    drive(6'h00, 6'h08, 5'h0, 5'h0, 16'h0, 26'h0, addr, 32'h0);
    tick();
    driveNop();
    tick();
  endtask

  function automatic string tagOf(input vec_t v);
    if (v.op == 6'h01) return "R5";
    if (v.op == 6'h02 || v.op == 6'h03) return "R6";
    if (v.op == 6'h00 && (v.fn == 6'h08 || v.fn == 6'h09)) return "R7";
    if (v.op >= 6'h04 && v.op <= 6'h07) return "R4";
    return "R2";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    driveNop();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 reset pc", pc, RV);
    check("R1 reset pend", 32'(pendValid), 32'h0);
    tick();
    check("R2 step after reset", pc, RV + 32'h4);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v  = VECS[i];
      tg = tagOf(v);
      jumpTo(v.startPc);
      drive(v.op, v.fn, v.rtF, v.rdF, v.off, v.idx, v.rsV, v.rtV);
      #1;
      check("R8 linkWe", 32'(linkWe), 32'(v.lw));
      if (v.lw) begin
        check("R8 linkReg", 32'(linkReg), 32'(v.lr));
        check("R8 linkData", linkData, v.startPc + 32'h8);
      end
      tick();
      check("R3 pc after transfer cycle", pc, v.startPc + 32'h4);
      check({tg, " taken"}, 32'(pendValid), 32'(v.taken));
      if (v.taken) check({tg, " destination"}, pendTarget, v.target);
      driveNop();
      tick();
      check({tg, " pc after slot"}, pc, v.taken ? v.target : v.startPc + 32'h8);
      check("R10 pend cleared", 32'(pendValid), 32'h0);
    end

    // R9: jump-and-link placed in the delay slot of a taken branch
    jumpTo(32'h100);
    drive(6'h04, 6'h00, 5'h0, 5'h0, 16'h0010, 26'h0, 32'h5, 32'h5);
    tick();
    check("R3 pend set", 32'(pendValid), 32'h1);
    drive(6'h03, 6'h00, 5'h0, 5'h0, 16'h0, 26'h1000, 32'h0, 32'h0);
    #1;
    check("R9 no link in slot", 32'(linkWe), 32'h0);
    tick();
    check("R9 pc to held destination", pc, 32'h144);
    check("R9 no new pending", 32'(pendValid), 32'h0);
    driveNop();
    tick();
    check("R9 slot jump had no effect", pc, 32'h148);

    // R1: reset over an outstanding destination
    jumpTo(32'h0);
    drive(6'h02, 6'h00, 5'h0, 5'h0, 16'h0, 26'h40, 32'h0, 32'h0);
    tick();
    check("R3 pend before reset", 32'(pendValid), 32'h1);
    driveNop();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1 reset wins pc", pc, RV);
    check("R1 reset wins pend", 32'(pendValid), 32'h0);
    tick();
    check("R1 runs on from vector", pc, RV + 32'h4);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule